// File: doc/BRIEF.md
# Dual-Buffer Serial Flash Command Front-End

This block is the command side of a serial flash device. A host talks to it over a mode-0 SPI link: chip select low, data in on the rising clock edge, data out on the falling edge, most significant bit first. Each command starts with a one-byte opcode. Array commands follow the opcode with a 24-bit address. The block holds two page-sized SRAM buffers and a small main-memory array, all sized by parameters. It moves whole pages between them.

A host fills a buffer and programs it into a page with one command. The programming starts when chip select returns high. The host can also copy a page into either buffer, or compare a page with a buffer. Array operations run for a set number of system clocks, counted by an internal timer. The host learns when an operation has finished by polling the status byte, or by watching the busy pin. The serial pins are synchronised to the system clock, so SCK must run well below the system clock rate.

Top module: `flash_fe_top`

## Requirements
- R1: Opcode 82h (buffer 0) or 85h (buffer 1), then the address, then data bytes. Each data byte is written into the selected buffer, starting at the address's byte field. At the rising edge of chip select, the whole buffer is programmed into the addressed page.
- R2: The 24-bit address is sent most significant byte first. Bit 23 is ignored. The page number sits directly above the low BYTE_FIELD_W bits: 10 bits for the standard page size, 9 for the power-of-two size. The low bits of the byte field give the starting byte.
- R3: A page of the main array changes only when a program operation completes. Completion happens PROG_CYCLES clocks after the commit starts.
- R4: The busy output goes high a few clocks after the chip-select rising edge that ends an accepted array command. It stays high for PROG_CYCLES clocks (program) or XFER_CYCLES clocks (transfer and compare).
- R5: Opcode 60h (buffer 0) or 61h (buffer 1) compares the addressed page with the buffer. When the compare completes, status bit 6 is set to 1 if any bit differs, or cleared to 0 if the page and buffer match.
- R6: The buffer byte pointer advances after every data byte. After the last byte of the page it wraps to byte 0.
- R7: Opcode 53h (buffer 0) or 55h (buffer 1) copies the addressed page into the buffer. The copy happens when the operation completes.
- R8: Opcode D7h returns the status byte again and again while chip select stays low. Bit 7 is 1 when the device is ready. Bit 6 is the compare result. Bits 5:0 are 0. SI is sampled on the rising SCK edge and SO changes on the falling edge.
- R9: While busy, an array opcode is ignored and has no effect on buffers, array or timing. A status read is still served.
- R10: so_oe is low while chip select is high and high while it is low. SO is driven only when so_oe is high.
- R11: If chip select rises before all three address bytes have arrived, the array command is dropped and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; the pad tri-states when this is low |
| busy | output | 1 | High while an array operation is in progress |

## Verification
Errors in the buffers or the array stay hidden until a compare exposes them. A wrong pointer step or a wrong page index shows up as a wrong status bit 6, one compare time after the first compare that reads the damaged page. A timer fault shows on the busy pin within a few clocks of where the edge should have been, so the bench checks busy against its model on every clock. A command-decoder fault that lets an array command through while busy shows up as a shifted busy window. It can also show later as a mismatch that the model does not predict.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_HOLD,
        ST_STAT,
        ST_SKIP
    } cmd_state_e;

    typedef enum logic [1:0] {
        OP_PROG,
        OP_XFER,
        OP_CMP
    } arr_op_e;

    localparam logic [7:0] OPC_PROG_B0 = 8'h82;
    localparam logic [7:0] OPC_PROG_B1 = 8'h85;
    localparam logic [7:0] OPC_XFER_B0 = 8'h53;
    localparam logic [7:0] OPC_XFER_B1 = 8'h55;
    localparam logic [7:0] OPC_CMP_B0  = 8'h60;
    localparam logic [7:0] OPC_CMP_B1  = 8'h61;
    localparam logic [7:0] OPC_STATUS  = 8'hD7;

endpackage

// File: rtl/flash_fe_sync.sv
module flash_fe_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] st_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= {2{RST_VAL[i]}};
            else        st_q <= {st_q[0], d_i[i]};
        end
        assign q_o[i] = st_q[1];
    end

endmodule

// File: rtl/flash_fe_spi.sv
module flash_fe_spi (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_i,
    input  logic       sck_i,
    input  logic       si_i,
    input  logic [7:0] tx_byte_i,
    output logic [7:0] rx_byte_o,
    output logic       rx_valid_o,
    output logic       cs_rise_o,
    output logic       so_o,
    output logic       so_oe_o
);

    typedef struct packed {
        logic       sck_p;
        logic       cs_p;
        logic [2:0] bit_cnt;
        logic [6:0] rx_sh;
        logic [7:0] tx_sh;
        logic       so;
        logic [7:0] rx_byte;
        logic       rx_valid;
        logic       cs_rise;
    } spi_s;

    spi_s q, n;
    logic sck_rise, sck_fall;

    always_comb begin
        n          = q;
        n.rx_valid = 1'b0;
        n.cs_rise  = 1'b0;
        n.sck_p    = sck_i;
        n.cs_p     = cs_n_i;
        sck_rise   = sck_i & ~q.sck_p & ~cs_n_i;
        sck_fall   = ~sck_i & q.sck_p & ~cs_n_i;

        if (cs_n_i) n.bit_cnt = '0;
        if (cs_n_i && !q.cs_p) n.cs_rise = 1'b1;

        if (sck_rise) begin
            n.rx_sh   = {q.rx_sh[5:0], si_i};
            n.bit_cnt = q.bit_cnt + 3'd1;
            if (q.bit_cnt == 3'd7) begin
                n.rx_valid = 1'b1;
                n.rx_byte  = {q.rx_sh, si_i};
            end
        end

        if (sck_fall) begin
            if (q.bit_cnt == 3'd0) begin
                n.so    = tx_byte_i[7];
                n.tx_sh = {tx_byte_i[6:0], 1'b0};
            end else begin
                n.so    = q.tx_sh[7];
                n.tx_sh = {q.tx_sh[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cs_p  <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign rx_byte_o  = q.rx_byte;
    assign rx_valid_o = q.rx_valid;
    assign cs_rise_o  = q.cs_rise;
    assign so_o       = q.so;
    assign so_oe_o    = ~q.cs_p;

    // R8: the output bit moves only after a detected falling SCK edge
    p_so_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.so) |-> $past(sck_fall));

    // R8: a received byte is flagged only when eight bits have been taken
    p_byte_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.rx_valid |-> (q.bit_cnt == 3'd0));

endmodule

// File: rtl/flash_fe_core.sv
module flash_fe_core
    import flash_fe_pkg::*;
#(
    parameter int PAGE_BYTES   = 16,
    parameter int NUM_PAGES    = 4,
    parameter int BYTE_FIELD_W = 10,
    parameter int PROG_CYCLES  = 2000,
    parameter int XFER_CYCLES  = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_byte_i,
    input  logic       rx_valid_i,
    input  logic       cs_rise_i,
    output logic [7:0] status_o,
    output logic       busy_o
);

    localparam int PG_BITS = PAGE_BYTES * 8;
    localparam int BY_W    = $clog2(PAGE_BYTES);
    localparam int PA_W    = $clog2(NUM_PAGES);
    localparam int AW      = BYTE_FIELD_W + PA_W;
    localparam int MAX_T   = (PROG_CYCLES > XFER_CYCLES) ? PROG_CYCLES : XFER_CYCLES;
    localparam int TW      = $clog2(MAX_T + 1);

    typedef struct packed {
        cmd_state_e                          st;
        arr_op_e                             op;
        logic                                bsel;
        logic [1:0]                          acnt;
        logic [AW-1:0]                       addr;
        logic [BY_W-1:0]                     ptr;
        logic                                busy;
        logic [TW-1:0]                       timer;
        logic                                mis;
        logic [1:0][PG_BITS-1:0]             bufs;
        logic [NUM_PAGES-1:0][PG_BITS-1:0]   mem;
    } core_s;

    core_s q, n;
    logic [PA_W-1:0] pg;
    logic [BY_W-1:0] start_raw;

    assign pg = q.addr[BYTE_FIELD_W +: PA_W];

    always_comb begin
        n         = q;
        start_raw = '0;

        // self-timed array operation
        if (q.busy) begin
            if (q.timer <= TW'(1)) begin
                n.busy  = 1'b0;
                n.timer = '0;
                case (q.op)
                    OP_PROG: n.mem[pg]       = q.bufs[q.bsel];
                    OP_XFER: n.bufs[q.bsel]  = q.mem[pg];
                    default: n.mis           = (q.mem[pg] != q.bufs[q.bsel]);
                endcase
            end else begin
                n.timer = q.timer - TW'(1);
            end
        end

        if (rx_valid_i) begin
            case (q.st)
                ST_OPC: begin
                    if (rx_byte_i == OPC_STATUS) begin
                        n.st = ST_STAT;
                    end else if (q.busy) begin
                        n.st = ST_SKIP;
                    end else begin
                        n.st   = ST_ADDR;
                        n.acnt = '0;
                        case (rx_byte_i)
                            OPC_PROG_B0: begin n.op = OP_PROG; n.bsel = 1'b0; end
                            OPC_PROG_B1: begin n.op = OP_PROG; n.bsel = 1'b1; end
                            OPC_XFER_B0: begin n.op = OP_XFER; n.bsel = 1'b0; end
                            OPC_XFER_B1: begin n.op = OP_XFER; n.bsel = 1'b1; end
                            OPC_CMP_B0:  begin n.op = OP_CMP;  n.bsel = 1'b0; end
                            OPC_CMP_B1:  begin n.op = OP_CMP;  n.bsel = 1'b1; end
                            default:     n.st = ST_SKIP;
                        endcase
                    end
                end
                ST_ADDR: begin
                    n.addr = AW'({q.addr, rx_byte_i});
                    n.acnt = q.acnt + 2'd1;
                    if (q.acnt == 2'd2) begin
                        n.st      = (q.op == OP_PROG) ? ST_DATA : ST_HOLD;
                        start_raw = n.addr[BY_W-1:0];
                        n.ptr     = (32'(start_raw) < PAGE_BYTES) ? start_raw : '0;
                    end
                end
                ST_DATA: begin
                    n.bufs[q.bsel][{q.ptr, 3'b000} +: 8] = rx_byte_i;
                    n.ptr = (q.ptr == BY_W'(PAGE_BYTES - 1)) ? '0 : q.ptr + BY_W'(1);
                end
                default: ;
            endcase
        end

        if (cs_rise_i) begin
            if ((q.st == ST_DATA || q.st == ST_HOLD) && !q.busy) begin
                n.busy  = 1'b1;
                n.timer = (q.op == OP_PROG) ? TW'(PROG_CYCLES) : TW'(XFER_CYCLES);
            end
            n.st = ST_OPC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_OPC;
            q.op <= OP_PROG;
        end else begin
            q <= n;
        end
    end

    assign status_o = {~q.busy, q.mis, 6'b000000};
    assign busy_o   = q.busy;

    // R3: the array only changes as an operation retires
    p_array_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.mem) |-> $past(q.busy));

    // R4: busy begins only on the end of a command
    p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(cs_rise_i));

    // R5: the compare flag only moves as an operation retires
    p_mis_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.mis) |-> $past(q.busy));

    // R6: during data loading the pointer steps by one or wraps to zero
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_DATA && q.st == ST_DATA && !$stable(q.ptr))
            |-> (q.ptr == $past(q.ptr) + BY_W'(1) || q.ptr == '0));

    // R9: an opcode arriving while busy never opens an array command
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && rx_valid_i && q.st == ST_OPC && !cs_rise_i)
            |=> (q.st == ST_STAT || q.st == ST_SKIP));

endmodule

// File: rtl/flash_fe_top.sv
module flash_fe_top #(
    parameter int PAGE_BYTES   = 16,
    parameter int NUM_PAGES    = 4,
    parameter int BYTE_FIELD_W = 10,
    parameter int PROG_CYCLES  = 2000,
    parameter int XFER_CYCLES  = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic so_oe,
    output logic busy
);

    logic [2:0] pins_s;
    logic [7:0] rx_byte, status;
    logic       rx_valid, cs_rise;

    flash_fe_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n, sck, si}),
        .q_o   (pins_s)
    );

    flash_fe_spi u_spi (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (pins_s[2]),
        .sck_i      (pins_s[1]),
        .si_i       (pins_s[0]),
        .tx_byte_i  (status),
        .rx_byte_o  (rx_byte),
        .rx_valid_o (rx_valid),
        .cs_rise_o  (cs_rise),
        .so_o       (so),
        .so_oe_o    (so_oe)
    );

    flash_fe_core #(
        .PAGE_BYTES   (PAGE_BYTES),
        .NUM_PAGES    (NUM_PAGES),
        .BYTE_FIELD_W (BYTE_FIELD_W),
        .PROG_CYCLES  (PROG_CYCLES),
        .XFER_CYCLES  (XFER_CYCLES)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_byte_i  (rx_byte),
        .rx_valid_i (rx_valid),
        .cs_rise_i  (cs_rise),
        .status_o   (status),
        .busy_o     (busy)
    );

endmodule

// File: tb/flash_fe_top_tb.sv
module flash_fe_top_tb;

    localparam int PB     = 16;
    localparam int NP     = 4;
    localparam int PROG_T = 2000;
    localparam int XFER_T = 300;
    localparam int HALF   = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic so, so_oe, busy;

    always #10 clk = ~clk;

    flash_fe_top #(
        .PAGE_BYTES(PB), .NUM_PAGES(NP), .BYTE_FIELD_W(10),
        .PROG_CYCLES(PROG_T), .XFER_CYCLES(XFER_T)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .busy(busy)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int cs_hi_run = 0;
    int cs_lo_run = 0;
    int bz_start = -100000;
    int bz_len = 0;
    bit finished = 0;

    logic [7:0] mbuf [2][PB];
    logic [7:0] mmem [NP][PB];
    logic       mmis = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_busy();
        return (cyc <= bz_start + bz_len + 8) && (cyc >= bz_start);
    endfunction

    function automatic bit differs(input int b, input int p);
        for (int i = 0; i < PB; i++)
            if (mbuf[b][i] != mmem[p][i]) return 1'b1;
        return 1'b0;
    endfunction

    // per-clock reference comparison of busy and output enable
    always @(negedge clk) begin
        cyc++;
        if (cs_n) begin cs_hi_run++; cs_lo_run = 0; end
        else      begin cs_lo_run++; cs_hi_run = 0; end
        if (rst_n && !finished) begin
            if (cs_hi_run > 4) check(so_oe == 1'b0, "R10", "so_oe while deselected", so_oe, 0);
            if (cs_lo_run > 4) check(so_oe == 1'b1, "R10", "so_oe while selected", so_oe, 1);
            if (!((cyc >= bz_start && cyc < bz_start + 6) ||
                  (cyc > bz_start + bz_len && cyc <= bz_start + bz_len + 6))) begin
                automatic bit inwin = (cyc >= bz_start + 6) && (cyc <= bz_start + bz_len);
                check(busy == inwin, "R4", "busy window", busy, inwin);
            end
        end
    end

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            si = tx[i];
            #(HALF);
            rx[i] = so;
            sck = 1'b1;
            #(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] dummy;
        spi_byte(tx, dummy);
    endtask

    task automatic end_cmd(input bit commit, input int t);
        #(HALF);
        cs_n = 1'b1;
        if (commit) begin
            bz_start = cyc;
            bz_len = t;
        end
        #(2 * HALF);
    endtask

    task automatic send_addr(input int page, input int off, input bit top, input int n);
        logic [23:0] a;
        a = {top, 13'(page), 10'(off)};
        if (n > 0) send(a[23:16]);
        if (n > 1) send(a[15:8]);
        if (n > 2) send(a[7:0]);
    endtask

    task automatic do_prog(input bit b, input int page, input int off,
                           input logic [7:0] data[$], input bit top);
        bit ok;
        int p;
        ok = !model_busy();
        cs_n = 1'b0; #(HALF);
        send(b ? 8'h85 : 8'h82);
        send_addr(page, off, top, 3);
        p = off % PB;
        foreach (data[i]) begin
            send(data[i]);
            if (ok) mbuf[b][p] = data[i];
            p = (p + 1) % PB;
        end
        end_cmd(ok, PROG_T);
        if (ok) for (int i = 0; i < PB; i++) mmem[page % NP][i] = mbuf[b][i];
    endtask

    task automatic do_xfer(input bit b, input int page, input int naddr);
        bit ok;
        ok = !model_busy() && naddr == 3;
        cs_n = 1'b0; #(HALF);
        send(b ? 8'h55 : 8'h53);
        send_addr(page, 0, 1'b0, naddr);
        end_cmd(ok, XFER_T);
        if (ok) for (int i = 0; i < PB; i++) mbuf[b][i] = mmem[page % NP][i];
    endtask

    task automatic do_cmp(input bit b, input int page);
        bit ok;
        ok = !model_busy();
        cs_n = 1'b0; #(HALF);
        send(b ? 8'h61 : 8'h60);
        send_addr(page, 0, 1'b0, 3);
        end_cmd(ok, XFER_T);
        if (ok) mmis = differs(b, page % NP);
    endtask

    task automatic read_status(input int n, input bit chk, input string req,
                               output logic [7:0] last);
        logic [7:0] exp;
        cs_n = 1'b0; #(HALF);
        send(8'hD7);
        for (int i = 0; i < n; i++) begin
            exp = {~model_busy(), mmis, 6'b000000};
            spi_byte(8'h00, last);
            if (chk) check(last == exp, req, "status byte", last, exp);
        end
        end_cmd(1'b0, 0);
    endtask

    task automatic wait_ready();
        logic [7:0] st;
        bit got;
        got = 0;
        for (int k = 0; k < 100 && !got; k++) begin
            read_status(1, 1'b0, "", st);
            got = st[7];
        end
        check(got, "R4", "ready reached", got, 1);
        #(20 * 12);
    endtask

    initial begin
        #(20 * 190000);
        check(1'b0, "R4", "watchdog expired", 0, 1);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] st;
        logic [7:0] da[$];
        logic [7:0] db[$];
        logic [7:0] dc[$];
        for (int b = 0; b < 2; b++) for (int i = 0; i < PB; i++) mbuf[b][i] = 8'h00;
        for (int p = 0; p < NP; p++) for (int i = 0; i < PB; i++) mmem[p][i] = 8'h00;
        for (int i = 0; i < PB; i++) da.push_back(8'(i * 37 + 5));
        for (int i = 0; i < PB + 2; i++) db.push_back(8'(8'hA0 ^ (i * 13)));

        #3;
        #(HALF);
        rst_n = 1'b1;
        #(2 * HALF);

        // reset state
        check(busy == 1'b0, "R4", "busy after reset", busy, 0);
        check(so_oe == 1'b0, "R10", "so_oe after reset", so_oe, 0);
        read_status(1, 1'b1, "R8", st);

        // R1: program page 2 through buffer 0; R8/R4 status shows busy
        do_prog(1'b0, 2, 0, da, 1'b0);
        read_status(2, 1'b1, "R8", st);
        check(st[7] == 1'b0, "R4", "not ready during program", st[7], 0);
        // R9: transfer of page 0 into buffer 0 while busy is dropped
        do_xfer(1'b0, 0, 3);
        wait_ready();

        // R1/R3/R9: page 2 now equals buffer 0
        do_cmp(1'b0, 2);
        wait_ready();
        read_status(1, 1'b1, "R9", st);
        check(st[6] == 1'b0, "R1", "page vs buffer 0", st[6], 0);

        // R7: copy page 2 into buffer 1 then compare
        do_xfer(1'b1, 2, 3);
        wait_ready();
        do_cmp(1'b1, 2);
        wait_ready();
        read_status(1, 1'b1, "R7", st);

        // R5: mismatch against an empty page
        do_cmp(1'b1, 1);
        wait_ready();
        read_status(1, 1'b1, "R5", st);
        check(st[6] == 1'b1, "R5", "mismatch flag", st[6], 1);

        // R6: load past the page end, wrapping to byte 0
        do_prog(1'b1, 3, PB - 2, db, 1'b0);
        wait_ready();
        for (int i = 0; i < PB; i++) dc.push_back(mbuf[1][i]);
        // R2: address bit 23 set is ignored
        do_prog(1'b0, 1, 0, dc, 1'b1);
        wait_ready();
        do_cmp(1'b0, 3);
        wait_ready();
        read_status(1, 1'b1, "R6", st);
        do_cmp(1'b1, 1);
        wait_ready();
        read_status(1, 1'b1, "R2", st);

        // R11: short address drops the transfer
        do_xfer(1'b1, 0, 2);
        #(20 * 20);
        check(busy == 1'b0, "R11", "no busy after short address", busy, 0);
        do_cmp(1'b1, 3);
        wait_ready();
        read_status(1, 1'b1, "R11", st);

        // R8: repeated status bytes within one select
        read_status(4, 1'b1, "R8", st);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule